// File: doc/BRIEF.md
# Software Transfer Activation Register

This block is the 8-bit control register that software uses to start a data-transfer engine and to pick the transfer descriptor that the engine fetches. The register has two fields. The top bit is an enable. A CPU write can set it but can never clear it. The lower seven bits hold a vector number, and the block turns that number into a 16-bit descriptor address.

While the enable is set, the block asks the transfer engine for service. The engine reports back four things: that it is busy, that it has finished a transfer, that its programmed count is exhausted, and the current value of its interrupt-on-completion select bit. From these the register decides whether the enable clears on its own or stays set. It also raises a one-clock end-of-transfer interrupt request.

While the enable is set, the vector field is write-protected. A standby input returns the whole register to zero. The reset input is asynchronous and active-low, and its release is synchronised inside the block over two clocks.

Top module: `swact_unit`

## Requirements
- R1: After reset, and on the clock after `standby_i` is high, the read value is 0x00, `end_irq_o` is 0 and the descriptor address is 0x0400.
- R2: A CPU write with bit 7 of `wr_data_i` equal to 1 sets the enable (read bit 7). A write with bit 7 equal to 0 leaves the enable unchanged.
- R3: A write loads bits 6..0 into the vector field (read bits 6..0) only when the enable reads 0 in that cycle. Otherwise the vector field keeps its value.
- R4: `desc_addr_o` equals 0x0400 plus the vector shifted left by one. For example, vector 0x10 gives 0x0420.
- R5: When `xfer_done_i` is high while the enable is 1, with `irq_sel_i` 0 and `cnt_end_i` 0, the enable reads 0 on the next clock.
- R6: When `xfer_done_i` is high while the enable is 1 and either `irq_sel_i` or `cnt_end_i` is 1, the enable stays 1.
- R7: While `xfer_busy_i` is high and no completion or select-clear event applies, the enable stays 1.
- R8: A `sel_clr_i` pulse clears the enable only after an end-of-transfer interrupt has been issued since the enable was set. Before that, the pulse has no effect.
- R9: `act_req_o` is high exactly when the enable is 1 and `xfer_busy_i` is 0.
- R10: `end_irq_o` is high for the single clock that follows a completion with the enable at 1 and either `irq_sel_i` or `cnt_end_i` at 1.
- R11: If a CPU write of bit 7 equal to 1 meets a hardware clear in the same cycle, the enable reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby; returns the register to zero |
| wr_en_i | input | 1 | CPU write strobe for the register |
| wr_data_i | input | 8 | CPU write data |
| rd_data_o | output | 8 | Register value: enable in bit 7, vector in bits 6..0 |
| xfer_busy_i | input | 1 | Transfer engine is moving data |
| xfer_done_i | input | 1 | One-clock pulse: a transfer has completed |
| cnt_end_i | input | 1 | The programmed transfer count is exhausted |
| irq_sel_i | input | 1 | Current value of the interrupt-on-completion select bit |
| sel_clr_i | input | 1 | One-clock pulse: the CPU wrote 0 to the select bit |
| act_req_o | output | 1 | Software activation request to the engine |
| desc_addr_o | output | 16 | Descriptor address derived from the vector |
| end_irq_o | output | 1 | End-of-transfer interrupt request pulse |

## Verification
The embedded properties check, on every cycle, the local rules of the enable bit:
- setting by write;
- the hardware clear;
- the two hold cases, including holding while the engine is busy;
- the select-clear path;
- the set-wins collision;
- the vector lock;
- the request gating;
- the interrupt pulse.

Some behaviour can only be shown by the bench's scenarios. These are the sequences that span several events: an interrupt issued and then followed by a select clear, a select clear arriving before any interrupt, and standby in the middle of a transfer. The same holds for the exact address values for particular vectors. A cycle-accurate reference model checks all of these against the full random traffic.

// File: rtl/swact_pkg.sv
package swact_pkg;
  localparam int unsigned VEC_W  = 7;
  localparam int unsigned REG_W  = VEC_W + 1;
  localparam int unsigned ADDR_W = 16;
  localparam logic [ADDR_W-1:0] DESC_BASE = 16'h0400;

  typedef struct packed {
    logic busy;
    logic done;
    logic cnt_end;
    logic irq_sel;
  } xfer_stat_t;
endpackage

// File: rtl/swact_rst_sync.sv
module swact_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/swact_vec.sv
module swact_vec
  import swact_pkg::*;
#(
  parameter int unsigned VW = VEC_W,
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] BASE = DESC_BASE
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          standby_i,
  input  logic          wr_en_i,
  input  logic [VW-1:0] wr_vec_i,
  input  logic          en_q_i,
  output logic [VW-1:0] vec_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned SHIFTED_W = VW + 1;

  logic [VW-1:0] vec_q;
  logic [VW-1:0] vec_d;
  logic          vec_ce;

  always_comb begin
    vec_ce = standby_i | (wr_en_i & ~en_q_i);
    vec_d  = standby_i ? '0 : wr_vec_i;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     vec_q <= '0;
    else if (vec_ce) vec_q <= vec_d;
  end

  generate
    if (AW > SHIFTED_W) begin : g_wide
      assign addr_o = BASE + {{(AW-SHIFTED_W){1'b0}}, vec_q, 1'b0};
    end else begin : g_narrow
      logic [SHIFTED_W-1:0] shifted;
      assign shifted = {vec_q, 1'b0};
      assign addr_o  = BASE + shifted[AW-1:0];
    end
  endgenerate

  assign vec_o = vec_q;

  p_vec_lock_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (en_q_i && !standby_i) |=> $stable(vec_q));
  p_addr_even_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (addr_o[0] == BASE[0]));
  p_standby_vec_r1: assert property (@(posedge clk) disable iff (!srst_n)
    standby_i |=> (vec_q == '0));
endmodule

// File: rtl/swact_irq.sv
module swact_irq
  import swact_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       standby_i,
  input  logic       en_q_i,
  input  xfer_stat_t stat_i,
  output logic       irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = ~standby_i & en_q_i & stat_i.done & (stat_i.irq_sel | stat_i.cnt_end);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  p_irq_fire_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!standby_i && en_q_i && stat_i.done && (stat_i.irq_sel || stat_i.cnt_end)) |=> irq_o);
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!stat_i.done || !en_q_i) |=> !irq_o);
endmodule

// File: rtl/swact_ctrl.sv
module swact_ctrl
  import swact_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       standby_i,
  input  logic       wr_set_i,
  input  logic       sel_clr_i,
  input  xfer_stat_t stat_i,
  input  logic       irq_i,
  output logic       en_o
);
  logic en_q, en_d;
  logic seen_q, seen_d;
  logic hw_clr, sel_path_clr;

  always_comb begin
    hw_clr       = en_q & stat_i.done & ~stat_i.irq_sel & ~stat_i.cnt_end;
    sel_path_clr = en_q & seen_q & sel_clr_i;
    if (standby_i)                   en_d = 1'b0;
    else if (wr_set_i)               en_d = 1'b1;
    else if (hw_clr || sel_path_clr) en_d = 1'b0;
    else                             en_d = en_q;
    seen_d = en_d & (seen_q | irq_i);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      seen_q <= seen_d;
    end
  end

  assign en_o = en_q;

  p_set_by_write_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (!standby_i && wr_set_i) |=> en_q);
  p_hw_clear_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (!standby_i && !wr_set_i && en_q && stat_i.done && !stat_i.irq_sel && !stat_i.cnt_end) |=> !en_q);
  p_hold_on_end_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!standby_i && en_q && stat_i.done && (stat_i.irq_sel || stat_i.cnt_end)
     && !(sel_clr_i && seen_q)) |=> en_q);
  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!standby_i && en_q && stat_i.busy && !stat_i.done && !(sel_clr_i && seen_q)) |=> en_q);
  p_sel_clear_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!standby_i && !wr_set_i && en_q && seen_q && sel_clr_i) |=> !en_q);
  p_sel_early_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!standby_i && en_q && !seen_q && !irq_i && sel_clr_i && !stat_i.done) |=> en_q);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (!standby_i && wr_set_i && en_q && stat_i.done && !stat_i.irq_sel && !stat_i.cnt_end) |=> en_q);
  p_standby_en_r1: assert property (@(posedge clk) disable iff (!srst_n)
    standby_i |=> !en_q);
endmodule

// File: rtl/swact_unit.sv
module swact_unit
  import swact_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              xfer_busy_i,
  input  logic              xfer_done_i,
  input  logic              cnt_end_i,
  input  logic              irq_sel_i,
  input  logic              sel_clr_i,
  output logic              act_req_o,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic              end_irq_o
);
  localparam int unsigned EN_BIT = REG_W - 1;

  logic             srst_n;
  logic             en;
  logic             irq;
  logic             wr_set;
  logic [VEC_W-1:0] vec;
  xfer_stat_t       stat;

  assign stat   = '{busy: xfer_busy_i, done: xfer_done_i, cnt_end: cnt_end_i, irq_sel: irq_sel_i};
  assign wr_set = wr_en_i & wr_data_i[EN_BIT];

  swact_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  swact_ctrl u_ctrl (
    .clk       (clk),
    .srst_n    (srst_n),
    .standby_i (standby_i),
    .wr_set_i  (wr_set),
    .sel_clr_i (sel_clr_i),
    .stat_i    (stat),
    .irq_i     (irq),
    .en_o      (en)
  );

  swact_vec u_vec (
    .clk       (clk),
    .srst_n    (srst_n),
    .standby_i (standby_i),
    .wr_en_i   (wr_en_i),
    .wr_vec_i  (wr_data_i[VEC_W-1:0]),
    .en_q_i    (en),
    .vec_o     (vec),
    .addr_o    (desc_addr_o)
  );

  swact_irq u_irq (
    .clk       (clk),
    .srst_n    (srst_n),
    .standby_i (standby_i),
    .en_q_i    (en),
    .stat_i    (stat),
    .irq_o     (irq)
  );

  assign rd_data_o = {en, vec};
  assign act_req_o = en & ~xfer_busy_i;
  assign end_irq_o = irq;

  p_req_gate_r9: assert property (@(posedge clk) disable iff (!srst_n)
    act_req_o |-> (rd_data_o[EN_BIT] && !xfer_busy_i));
  p_req_present_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_data_o[EN_BIT] && !xfer_busy_i) |-> act_req_o);
endmodule

// File: tb/sim_swact_unit.sv
module sim_swact_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0, wr_en = 1'b0, busy = 1'b0, done = 1'b0;
  logic        cend = 1'b0, sel = 1'b0, selclr = 1'b0;
  logic [7:0]  wdat = 8'h00;
  logic [7:0]  rd;
  logic        req, irq;
  logic [15:0] addr;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit live = 1'b0;

  int m_en = 0, m_vec = 0, m_irq = 0, m_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swact_unit u0 (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .wr_en_i(wr_en), .wr_data_i(wdat),
    .rd_data_o(rd), .xfer_busy_i(busy), .xfer_done_i(done), .cnt_end_i(cend),
    .irq_sel_i(sel), .sel_clr_i(selclr), .act_req_o(req), .desc_addr_o(addr),
    .end_irq_o(irq)
  );

  // behavioural reference, advanced on every rising edge once reset has settled
  always @(posedge clk) begin
    cycles++;
    if (live) begin
      int n_en;
      int n_irq;
      n_irq = (!standby && m_en && done && (sel || cend)) ? 1 : 0;
      n_en = m_en;
      if (standby) n_en = 0;
      else if (wr_en && wdat[7]) n_en = 1;
      else if (m_en && done && !sel && !cend) n_en = 0;
      else if (m_en && m_seen && selclr) n_en = 0;
      if (standby) m_vec = 0;
      else if (wr_en && !m_en) m_vec = wdat[6:0];
      m_seen = n_en ? ((m_seen || m_irq) ? 1 : 0) : 0;
      m_en = n_en;
      m_irq = n_irq;
    end
  end

  task automatic check(input string req_tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req_tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    check("R2 enable", int'(rd[7]), m_en);
    check("R3 vector", int'(rd[6:0]), m_vec);
    check("R4 address", int'(addr), 16'h0400 + (m_vec << 1));
    check("R9 request", int'(req), (m_en && !busy) ? 1 : 0);
    check("R10 interrupt", int'(irq), m_irq);
  endtask

  task automatic step(input logic s_wr, input logic [7:0] s_dat, input logic s_busy,
                      input logic s_done, input logic s_sel, input logic s_cend,
                      input logic s_selclr, input logic s_stby);
    wr_en = s_wr; wdat = s_dat; busy = s_busy; done = s_done;
    sel = s_sel; cend = s_cend; selclr = s_selclr; standby = s_stby;
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;
    // R1 reset state
    check("R1 reset read", int'(rd), 0);
    check("R1 reset addr", int'(addr), 16'h0400);
    check("R1 reset irq", int'(irq), 0);

    step(1, 8'h10, 0, 0, 0, 0, 0, 0);            // R3 vector load while disabled
    check("R4 vec 0x10", int'(addr), 16'h0420);
    step(1, 8'h10, 0, 0, 0, 0, 0, 0);            // R2 writing 0 to enable: no effect
    check("R2 zero write", int'(rd[7]), 0);
    step(1, 8'h85, 0, 0, 0, 0, 0, 0);            // R2 set, vector 5
    check("R4 vec 0x05", int'(addr), 16'h040A);
    step(1, 8'h22, 0, 0, 0, 0, 0, 0);            // R3 locked
    check("R3 locked", int'(rd), 8'h85);
    step(1, 8'h00, 1, 0, 0, 0, 0, 0);            // R7 busy, R2 zero write
    check("R9 busy no req", int'(req), 0);
    step(0, 8'h00, 1, 0, 0, 0, 1, 0);            // R8 early select clear ignored
    check("R8 early selclr", int'(rd[7]), 1);
    step(0, 8'h00, 0, 1, 0, 0, 0, 0);            // R5 hardware clear
    check("R5 hw clear", int'(rd[7]), 0);
    idle(2);
    step(1, 8'h81, 0, 0, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 1, 0, 0, 0);            // R6 hold with select
    check("R6 hold sel", int'(rd[7]), 1);
    check("R10 pulse", int'(irq), 1);
    step(0, 8'h00, 0, 0, 1, 0, 0, 0);
    check("R10 single", int'(irq), 0);
    step(0, 8'h00, 0, 0, 0, 0, 1, 0);            // R8 clear after interrupt
    check("R8 selclr", int'(rd[7]), 0);
    step(1, 8'h83, 0, 0, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 0, 1, 0, 0);            // R6 hold on count end
    check("R6 hold cend", int'(rd[7]), 1);
    step(1, 8'h80, 0, 1, 0, 0, 0, 0);            // R11 set beats hw clear
    check("R11 set wins", int'(rd[7]), 1);
    step(0, 8'h00, 1, 0, 0, 0, 0, 1);            // R1 standby
    check("R1 standby", int'(rd), 0);
    idle(2);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[0] & r[1], 8'($urandom), r[2], r[3] & r[4], r[5], r[6] & r[7],
           ($urandom % 4) == 0, ($urandom % 97) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule